// File: doc/BRIEF.md
# Accumulating Bit-Serial Adder

This block adds two unsigned operands of `WIDTH` bits using a single full-adder cell and one carry flip-flop. It processes one bit pair per clock. The running value sits in a right-shifting accumulator register, and the operand sits in a second right-shifting register. On every shift clock, the sum bit produced from the two low bits and the stored carry enters the top of the accumulator. The carry-out is kept for the next bit position.

A full addition takes `WIDTH` shift clocks. The operand register has a serial input of its own. While the current operand drains into the adder, the next operand can be streamed in, least significant bit first. Another start then adds that operand to the total without any parallel reload, so any number of operands can be summed in turn. Both registers can also be loaded in parallel while the block is idle. The final carry of each addition is shown on `carry_o`.

Top module: `serial_acc_adder`

## Requirements
- R1: After reset, `acc_o` is 0, `carry_o` is 0 and `done_o` is 0.
- R2: While idle, `load_acc_i` copies `acc_par_i` into the accumulator and `load_opd_i` copies `opd_par_i` into the operand register, at the next clock edge.
- R3: A start accepted at clock edge k causes shifts at edges k+1 through k+WIDTH. `done_o` is high for exactly the one cycle that follows edge k+WIDTH.
- R4: When `done_o` is high, `acc_o` equals (accumulator + operand) mod 2^WIDTH, using the values held when the start was accepted.
- R5: The carry flip-flop is cleared when a start is accepted. When `done_o` is high, `carry_o` equals bit WIDTH of the unsigned sum, so a carry left over from an earlier addition has no influence.
- R6: The bit on `opd_ser_i` during the i-th shift of an addition (i counted from 0) becomes bit i of the operand register. A following start therefore adds that serially supplied value to the accumulated total.
- R7: While an addition is running, `start_i`, `load_acc_i` and `load_opd_i` are ignored. The result and the timing of `done_o` are unchanged.
- R8: A start and a parallel load asserted in the same idle cycle both take effect. The addition uses the newly loaded values.
- R9: Once an addition has finished, `acc_o` holds its value in every later cycle without a load or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_acc_i | input | 1 | Parallel load of the accumulator (idle only) |
| acc_par_i | input | WIDTH | Parallel value for the accumulator |
| load_opd_i | input | 1 | Parallel load of the operand register (idle only) |
| opd_par_i | input | WIDTH | Parallel value for the operand register |
| start_i | input | 1 | Begin an addition (idle only) |
| opd_ser_i | input | 1 | Serial input feeding the operand register MSB, LSB first |
| done_o | output | 1 | One-cycle pulse when an addition finishes |
| carry_o | output | 1 | Carry flip-flop, final carry after done |
| acc_o | output | WIDTH | Accumulator register value |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a start and a parallel load arrive together in one idle cycle. The bench provokes this with fresh values on both parallel inputs and judges it by whether the result at `done_o` reflects the loaded values. In the second, a restart or load request arrives in the middle of an addition while the next operand is being shifted in serially. The scoreboard then expects the unchanged sum, with `done_o` exactly `WIDTH` cycles after the accepted start. In that second case, the following addition must consume the serially fed operand rather than the parallel value that was presented.

// File: rtl/serial_acc_pkg.sv
package serial_acc_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             shift_en_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_q <= '0;
    else if (shift_en_i) q_q <= {ser_i, q_q[WIDTH-1:1]};
    else if (load_en_i)  q_q <= load_val_i;
  end

  assign q_o = q_q;

  assert_shift_right_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (q_o[WIDTH-1] == $past(ser_i)) && (q_o[WIDTH-2:0] == $past(q_o[WIDTH-1:1])));

  assert_par_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en_i && !shift_en_i) |=> q_o == $past(load_val_i));
endmodule

// File: rtl/sa_fa_carry.sv
module sa_fa_carry (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic a_bit_i,
  input  logic b_bit_i,
  output logic sum_o,
  output logic carry_o
);
  logic carry_q;

  // JK behaviour: set on 1/1, clear on 0/0, hold otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      carry_q <= 1'b0;
    else if (clr_i)                   carry_q <= 1'b0;
    else if (en_i && a_bit_i && b_bit_i)   carry_q <= 1'b1;
    else if (en_i && !a_bit_i && !b_bit_i) carry_q <= 1'b0;
  end

  assign sum_o   = a_bit_i ^ b_bit_i ^ carry_q;
  assign carry_o = carry_q;

  assert_carry_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !carry_o);

  assert_carry_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && a_bit_i && b_bit_i) |=> carry_o);

  assert_carry_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (!en_i || (a_bit_i != b_bit_i))) |=> $stable(carry_o));
endmodule

// File: rtl/sa_sequencer.sv
module sa_sequencer
  import serial_acc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_SHIFT;
          cnt_q   <= '0;
        end
        SEQ_SHIFT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == SEQ_SHIFT);
  assign accept_o = start_i && (state_q == SEQ_IDLE);
  assign done_o   = done_q;

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_accept_begins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o && (cnt_q == '0));

  assert_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != LAST) |=> busy_o && (cnt_q == $past(cnt_q) + 1'b1));

  assert_finish_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == LAST) |=> !busy_o && done_o);
endmodule

// File: rtl/serial_acc_adder.sv
module serial_acc_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_acc_i,
  input  logic [WIDTH-1:0] acc_par_i,
  input  logic             load_opd_i,
  input  logic [WIDTH-1:0] opd_par_i,
  input  logic             start_i,
  input  logic             opd_ser_i,
  output logic             done_o,
  output logic             carry_o,
  output logic [WIDTH-1:0] acc_o
);
  logic             accept, busy, sum_bit;
  logic [WIDTH-1:0] acc_q, opd_q;

  sa_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_acc_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_en_i  (load_acc_i && !busy),
    .load_val_i (acc_par_i),
    .shift_en_i (busy),
    .ser_i      (sum_bit),
    .q_o        (acc_q)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_opd_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_en_i  (load_opd_i && !busy),
    .load_val_i (opd_par_i),
    .shift_en_i (busy),
    .ser_i      (opd_ser_i),
    .q_o        (opd_q)
  );

  sa_fa_carry u_fa (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .en_i    (busy),
    .a_bit_i (acc_q[0]),
    .b_bit_i (opd_q[0]),
    .sum_o   (sum_bit),
    .carry_o (carry_o)
  );

  assign acc_o = acc_q;

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !load_acc_i) |=> $stable(acc_o));

  assert_busy_ignores_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && load_acc_i) |=> acc_o[WIDTH-2:0] == $past(acc_o[WIDTH-1:1]));
endmodule

// File: tb/serial_acc_adder_tb.sv
module serial_acc_adder_tb;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] acc;
    logic         cy;
    int           t0;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_acc = 1'b0, load_opd = 1'b0, start = 1'b0, ser = 1'b0;
  logic [W-1:0] acc_par = '0, opd_par = '0;
  logic         done, carry;
  logic [W-1:0] acc;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  exp_t  sb[$];
  logic [W-1:0] m_acc = '0, m_opd = '0;
  logic  prev_done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_acc_adder #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .load_acc_i(load_acc), .acc_par_i(acc_par),
    .load_opd_i(load_opd), .opd_par_i(opd_par),
    .start_i(start), .opd_ser_i(ser),
    .done_o(done), .carry_o(carry), .acc_o(acc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R3", "done longer than one cycle", 32'd1, 32'd0);
      if (done) begin
        if (sb.size() == 0) chk(1'b0, "R3", "unexpected done", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(acc == e.acc, "R4", {e.tag, " sum"}, 32'(acc), 32'(e.acc));
          chk(carry == e.cy, "R5", {e.tag, " carry"}, 32'(carry), 32'(e.cy));
          chk(cyc - e.t0 == W, "R3", {e.tag, " latency"}, 32'(cyc - e.t0), 32'(W));
        end
      end
    end
    prev_done <= done;
  end

  task automatic load(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    load_acc = 1'b1; acc_par = a;
    load_opd = 1'b1; opd_par = b;
    @(negedge clk);
    load_acc = 1'b0; load_opd = 1'b0;
    m_acc = a; m_opd = b;
    chk(acc == a, "R2", "parallel load of accumulator", 32'(acc), 32'(a));
  endtask

  // run one addition; nxt is streamed serially as the next operand
  task automatic run_add(input logic [W-1:0] nxt, input bit disturb,
                         input bit with_load, input logic [W-1:0] la,
                         input logic [W-1:0] lb, input string tag);
    logic [W:0] s;
    exp_t e;
    @(negedge clk);
    start = 1'b1;
    if (with_load) begin
      load_acc = 1'b1; acc_par = la; load_opd = 1'b1; opd_par = lb;
      m_acc = la; m_opd = lb;
    end
    s = {1'b0, m_acc} + {1'b0, m_opd};
    @(negedge clk);
    start = 1'b0; load_acc = 1'b0; load_opd = 1'b0;
    e.acc = s[W-1:0]; e.cy = s[W]; e.t0 = cyc; e.tag = tag;
    sb.push_back(e);
    m_acc = s[W-1:0]; m_opd = nxt;
    for (int i = 0; i < W; i++) begin
      ser = nxt[i];
      if (disturb && i == 2) begin
        start = 1'b1; load_acc = 1'b1; load_opd = 1'b1;
        acc_par = ~m_acc; opd_par = 8'h5A;
      end else begin
        start = 1'b0; load_acc = 1'b0; load_opd = 1'b0;
      end
      @(negedge clk);
    end
    ser = 1'b0;
    @(negedge clk);
    chk(sb.size() == 0, "R3", {tag, " done seen"}, 32'(sb.size()), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R3", "watchdog expired", 32'(cyc), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(acc == '0, "R1", "reset acc", 32'(acc), 32'd0);
    chk(carry == 1'b0, "R1", "reset carry", 32'(carry), 32'd0);
    chk(done == 1'b0, "R1", "reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // basic adds, different patterns
    load(8'd23, 8'd42);
    run_add(8'd0, 1'b0, 1'b0, '0, '0, "R4 basic");
    load(8'hAA, 8'h55);
    run_add(8'd0, 1'b0, 1'b0, '0, '0, "R4 alternating");
    // overflow then a clean add: stale carry must not leak (R5)
    load(8'hFF, 8'h01);
    run_add(8'h10, 1'b0, 1'b0, '0, '0, "R5 overflow");
    run_add(8'h00, 1'b0, 1'b0, '0, '0, "R5 after overflow");

    // serial accumulation of several operands (R6)
    load(8'd5, 8'd7);
    run_add(8'd30, 1'b0, 1'b0, '0, '0, "R6 acc1");
    run_add(8'd200, 1'b0, 1'b0, '0, '0, "R6 acc2");
    run_add(8'd99, 1'b0, 1'b0, '0, '0, "R6 acc3");
    run_add(8'd0, 1'b0, 1'b0, '0, '0, "R6 acc4");

    // disturb during busy (R7): serial operand must still win
    load(8'h3C, 8'h81);
    run_add(8'h66, 1'b1, 1'b0, '0, '0, "R7 disturbed");
    run_add(8'h00, 1'b0, 1'b0, '0, '0, "R7 follow-up");

    // start and load in same idle cycle (R8)
    run_add(8'h00, 1'b0, 1'b1, 8'hC8, 8'h64, "R8 load+start");

    // idle hold (R9)
    repeat (5) @(negedge clk);
    chk(acc == m_acc, "R9", "acc holds while idle", 32'(acc), 32'(m_acc));
    chk(done == 1'b0, "R9", "no done while idle", 32'(done), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule